// File: doc/BRIEF.md
# Descriptor-Driven Transmit Frame Fetcher

This block sits between a host and a transmit MAC. The host loads frame data into a circular byte buffer through a 32-bit data port, fills entries of a small descriptor ring, and bumps a queued-frame counter once per frame. A start command then makes the block walk the ring from its current index. For each ready descriptor it turns the descriptor's pointer into a buffer offset and streams the frame's bytes out on a byte interface with a valid/ready handshake.

Each descriptor the walk visits is retired: its ready flag drops, the ring index moves on, and the queued count falls by one. Oversize and empty descriptors are retired without sending any bytes. The walk ends when the queued frames are used up or when it meets a descriptor that is not ready. It then emits a completion pulse, an error pulse, or both. A control reset clears the write pointer, the ring index and the queued count at any time.

Top module: `tx_frame_fetcher`

## Requirements
- R1: Each host data write stores the word at the write pointer and then advances the pointer by 4, modulo the buffer size. Byte k of the stored word, taken at bits 8k+7..8k, lands at byte address pointer+k.
- R2: While `swap_en` is high, a host word has its four bytes reversed before it is stored, so bits 31..24 land at byte address pointer+0.
- R3: Each cycle with `frame_inc` high raises the queued count by one. The count is zero after reset.
- R4: A start command handles at most the number of frames queued when it arrives. The walk stops at the first descriptor whose ready flag is clear. A start with nothing queued sends no bytes.
- R5: A frame's first byte is read from the buffer offset (pointer − `PTR_BASE`) modulo the buffer size.
- R6: When offset plus length passes the end of the buffer, the read carries on from offset 0.
- R7: A descriptor with a length above `MAX_LEN`, or a length of zero, sends no bytes but is still retired.
- R8: Each handled descriptor has its ready flag cleared. The ring index then advances, wrapping to 0 after `RING_DEPTH`−1, and the queued count drops by one.
- R9: When a walk ends, `irq_txend` pulses if at least one descriptor was handled. `irq_baddesc` pulses if fewer were handled than were queued, or if none were queued. Neither pulse appears while the block is busy.
- R10: A `ctrl_reset` cycle sets the write pointer, the queued count and the ring index to 0 and abandons any walk in progress.
- R11: `out_data` and `out_last` stay unchanged while `out_valid` is high and `out_ready` is low. `out_last` is high only on the final byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_en | input | 1 | Reverse byte order of host words |
| host_wr_en | input | 1 | Host data write strobe |
| host_wr_data | input | 32 | Host data word |
| frame_inc | input | 1 | Add one queued frame |
| ctrl_reset | input | 1 | Clear pointer, count and ring index |
| desc_we | input | 1 | Descriptor write strobe |
| desc_widx | input | log2(RING_DEPTH) | Descriptor index to write |
| desc_wready | input | 1 | Ready flag to write |
| desc_wlen | input | 16 | Frame length in bytes |
| desc_wptr | input | 16 | Frame pointer |
| desc_ridx | input | log2(RING_DEPTH) | Descriptor index to inspect |
| desc_rready | output | 1 | Ready flag of the inspected descriptor |
| start | input | 1 | Start a ring walk |
| busy | output | 1 | Walk in progress |
| wr_ptr | output | log2(BUF_BYTES) | Current write pointer |
| queued | output | CNT_W | Queued-frame count |
| ring_idx | output | log2(RING_DEPTH) | Current ring index |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Byte accepted |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| irq_txend | output | 1 | Completion pulse |
| irq_baddesc | output | 1 | Invalid-descriptor pulse |

## Verification
The bench builds the block with a 256-byte buffer and a four-entry ring, and keeps the default `PTR_BASE` and `MAX_LEN`. The small buffer lets 64 host writes take the write pointer all the way round, and lets ordinary frames cross the buffer end. A maximum-length frame then wraps the buffer several times. The four-entry ring reaches its index wrap within a handful of frames. Pointers both below and above the base exercise the modulo offset.

// File: rtl/tx_fetch_pkg.sv
package tx_fetch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_RETIRE,
        ST_DONE
    } fetch_state_e;

    typedef struct packed {
        logic        ready;
        logic [15:0] len;
        logic [15:0] ptr;
    } tx_desc_t;

    function automatic logic [31:0] rev_bytes32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/tx_buf_store.sv
module tx_buf_store #(
    parameter int BUF_BYTES = 16384,
    localparam int AW    = $clog2(BUF_BYTES),
    localparam int WORDS = BUF_BYTES / 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [31:0]   wr_data,
    input  logic          swap_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte,
    output logic [AW-1:0] wr_ptr
);
    import tx_fetch_pkg::*;

    logic [31:0]   mem_q [WORDS];
    logic [AW-1:0] wp_q;
    logic [31:0]   store_word;
    logic [31:0]   rd_word;

    assign store_word = swap_en ? rev_bytes32(wr_data) : wr_data;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp_q <= '0;
        end else if (wr_en) begin
            wp_q <= wp_q + AW'(4);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !rst && !clr) begin
            mem_q[wp_q[AW-1:2]] <= store_word;
        end
    end

    assign rd_word = mem_q[rd_addr[AW-1:2]];
    assign rd_byte = rd_word[{rd_addr[1:0], 3'b000} +: 8];
    assign wr_ptr  = wp_q;

endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring #(
    parameter int RING_DEPTH = 64,
    localparam int RAW = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [RAW-1:0]        widx,
    input  tx_fetch_pkg::tx_desc_t wdesc,
    input  logic                  clr_en,
    input  logic [RAW-1:0]        cur_idx,
    output tx_fetch_pkg::tx_desc_t cur_desc,
    input  logic [RAW-1:0]        peek_idx,
    output logic                  peek_ready
);
    import tx_fetch_pkg::*;

    tx_desc_t ent_q [RING_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RING_DEPTH; i++) begin
                ent_q[i].ready <= 1'b0;
            end
        end else begin
            if (clr_en) begin
                ent_q[cur_idx].ready <= 1'b0;
            end
            if (we) begin
                ent_q[widx] <= wdesc;
            end
        end
    end

    assign cur_desc   = ent_q[cur_idx];
    assign peek_ready = ent_q[peek_idx].ready;

endmodule

// File: rtl/tx_fetch_ctrl.sv
module tx_fetch_ctrl #(
    parameter int BUF_BYTES  = 16384,
    parameter int RING_DEPTH = 64,
    parameter int CNT_W      = 8,
    parameter int PTR_BASE   = 4096,
    parameter int MAX_LEN    = 1514,
    localparam int AW  = $clog2(BUF_BYTES),
    localparam int RAW = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctrl_reset,
    input  logic                   start,
    input  logic                   frame_inc,
    input  tx_fetch_pkg::tx_desc_t desc,
    input  logic                   out_ready,
    output logic [RAW-1:0]         ring_idx,
    output logic [CNT_W-1:0]       queued,
    output logic [AW-1:0]          rd_addr,
    output logic                   out_valid,
    output logic                   out_last,
    output logic                   busy,
    output logic                   clr_en,
    output logic                   irq_txend,
    output logic                   irq_baddesc
);
    import tx_fetch_pkg::*;

    fetch_state_e   state_q;
    logic [RAW-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q, todo_q, done_q;
    logic [AW-1:0]  addr_q;
    logic [15:0]    remain_q;
    logic           txend_q, bad_q;
    logic [15:0]    offset_full;
    logic           skip_desc;
    logic           retire;

    assign offset_full = desc.ptr - 16'(PTR_BASE);
    assign skip_desc   = (desc.len > 16'(MAX_LEN)) || (desc.len == 16'd0);
    assign retire      = (state_q == ST_RETIRE);

    always_ff @(posedge clk) begin
        if (rst || ctrl_reset) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(frame_inc) - CNT_W'(retire);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl_reset) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            todo_q   <= '0;
            done_q   <= '0;
            addr_q   <= '0;
            remain_q <= '0;
            txend_q  <= 1'b0;
            bad_q    <= 1'b0;
        end else begin
            txend_q <= 1'b0;
            bad_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        todo_q  <= cnt_q;
                        done_q  <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (done_q == todo_q || !desc.ready) begin
                        state_q <= ST_DONE;
                    end else if (skip_desc) begin
                        state_q <= ST_RETIRE;
                    end else begin
                        addr_q   <= offset_full[AW-1:0];
                        remain_q <= desc.len;
                        state_q  <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (out_ready) begin
                        addr_q   <= addr_q + AW'(1);
                        remain_q <= remain_q - 16'd1;
                        if (remain_q == 16'd1) begin
                            state_q <= ST_RETIRE;
                        end
                    end
                end
                ST_RETIRE: begin
                    idx_q   <= (idx_q == RAW'(RING_DEPTH - 1)) ? '0 : idx_q + RAW'(1);
                    done_q  <= done_q + CNT_W'(1);
                    state_q <= ST_FETCH;
                end
                ST_DONE: begin
                    bad_q   <= (done_q != todo_q) || (todo_q == '0);
                    txend_q <= (done_q != '0);
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ring_idx    = idx_q;
    assign queued      = cnt_q;
    assign rd_addr     = addr_q;
    assign out_valid   = (state_q == ST_SEND);
    assign out_last    = (state_q == ST_SEND) && (remain_q == 16'd1);
    assign busy        = (state_q != ST_IDLE);
    assign clr_en      = retire;
    assign irq_txend   = txend_q;
    assign irq_baddesc = bad_q;

endmodule

// File: rtl/tx_frame_fetcher.sv
module tx_frame_fetcher #(
    parameter int BUF_BYTES  = 16384,
    parameter int RING_DEPTH = 64,
    parameter int CNT_W      = 8,
    parameter int PTR_BASE   = 4096,
    parameter int MAX_LEN    = 1514,
    localparam int BUF_AW  = $clog2(BUF_BYTES),
    localparam int RING_AW = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               swap_en,
    input  logic               host_wr_en,
    input  logic [31:0]        host_wr_data,
    input  logic               frame_inc,
    input  logic               ctrl_reset,
    input  logic               desc_we,
    input  logic [RING_AW-1:0] desc_widx,
    input  logic               desc_wready,
    input  logic [15:0]        desc_wlen,
    input  logic [15:0]        desc_wptr,
    input  logic [RING_AW-1:0] desc_ridx,
    output logic               desc_rready,
    input  logic               start,
    output logic               busy,
    output logic [BUF_AW-1:0]  wr_ptr,
    output logic [CNT_W-1:0]   queued,
    output logic [RING_AW-1:0] ring_idx,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data,
    output logic               out_last,
    output logic               irq_txend,
    output logic               irq_baddesc
);
    import tx_fetch_pkg::*;

    tx_desc_t           wdesc;
    tx_desc_t           cur_desc;
    logic               clr_en;
    logic [BUF_AW-1:0]  rd_addr;

    assign wdesc = '{ready: desc_wready, len: desc_wlen, ptr: desc_wptr};

    tx_buf_store #(.BUF_BYTES(BUF_BYTES)) buf_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctrl_reset),
        .wr_en   (host_wr_en),
        .wr_data (host_wr_data),
        .swap_en (swap_en),
        .rd_addr (rd_addr),
        .rd_byte (out_data),
        .wr_ptr  (wr_ptr)
    );

    tx_desc_ring #(.RING_DEPTH(RING_DEPTH)) ring_i (
        .clk        (clk),
        .rst        (rst),
        .we         (desc_we),
        .widx       (desc_widx),
        .wdesc      (wdesc),
        .clr_en     (clr_en),
        .cur_idx    (ring_idx),
        .cur_desc   (cur_desc),
        .peek_idx   (desc_ridx),
        .peek_ready (desc_rready)
    );

    tx_fetch_ctrl #(
        .BUF_BYTES  (BUF_BYTES),
        .RING_DEPTH (RING_DEPTH),
        .CNT_W      (CNT_W),
        .PTR_BASE   (PTR_BASE),
        .MAX_LEN    (MAX_LEN)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .ctrl_reset  (ctrl_reset),
        .start       (start),
        .frame_inc   (frame_inc),
        .desc        (cur_desc),
        .out_ready   (out_ready),
        .ring_idx    (ring_idx),
        .queued      (queued),
        .rd_addr     (rd_addr),
        .out_valid   (out_valid),
        .out_last    (out_last),
        .busy        (busy),
        .clr_en      (clr_en),
        .irq_txend   (irq_txend),
        .irq_baddesc (irq_baddesc)
    );

endmodule

// File: rtl/tx_frame_fetcher_chk.sv
module tx_frame_fetcher_chk #(
    parameter int AW         = 14,
    parameter int RAW        = 6,
    parameter int CNT_W      = 8,
    parameter int RING_DEPTH = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr_en,
    input logic             frame_inc,
    input logic             ctrl_reset,
    input logic             busy,
    input logic [AW-1:0]    wr_ptr,
    input logic [CNT_W-1:0] queued,
    input logic [RAW-1:0]   ring_idx,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic             irq_txend,
    input logic             irq_baddesc
);

    a_r1_wrptr_step: assert property (@(posedge clk) disable iff (rst)
        host_wr_en && !ctrl_reset |=> wr_ptr == AW'($past(wr_ptr) + AW'(4)));

    a_r3_count_inc: assert property (@(posedge clk) disable iff (rst)
        frame_inc && !ctrl_reset && !busy |=> queued == CNT_W'($past(queued) + CNT_W'(1)));

    a_r8_ring_step: assert property (@(posedge clk) disable iff (rst)
        !ctrl_reset && busy |=> (ring_idx == $past(ring_idx)) ||
            (int'(ring_idx) == ((int'($past(ring_idx)) + 1) % RING_DEPTH)));

    a_r9_irq_idle: assert property (@(posedge clk) disable iff (rst)
        (irq_txend || irq_baddesc) |-> !busy && !out_valid);

    a_r10_ctrl_clear: assert property (@(posedge clk) disable iff (rst)
        ctrl_reset |=> wr_ptr == '0 && queued == '0 && ring_idx == '0 && !out_valid);

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !ctrl_reset |=> out_valid && $stable(out_last));

    a_r11_last_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

endmodule

bind tx_frame_fetcher tx_frame_fetcher_chk #(
    .AW         (BUF_AW),
    .RAW        (RING_AW),
    .CNT_W      (CNT_W),
    .RING_DEPTH (RING_DEPTH)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .host_wr_en  (host_wr_en),
    .frame_inc   (frame_inc),
    .ctrl_reset  (ctrl_reset),
    .busy        (busy),
    .wr_ptr      (wr_ptr),
    .queued      (queued),
    .ring_idx    (ring_idx),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_last    (out_last),
    .irq_txend   (irq_txend),
    .irq_baddesc (irq_baddesc)
);

// File: tb/tx_frame_fetcher_tb_top.sv
`timescale 1ns/1ps
module tx_frame_fetcher_tb_top;

    localparam int BUFB  = 256;
    localparam int RING  = 4;
    localparam int AW    = 8;
    localparam int RAW   = 2;
    localparam int NFR   = 6;
    // stimulus table: length, pointer, stall pattern, expected start offset
    localparam int FR_LEN  [NFR] = '{10, 7, 40, 1, 256, 9};
    localparam int FR_PTR  [NFR] = '{32'h1000, 32'h1003, 32'h10F0, 32'h10FF, 32'h1010, 32'h0FFC};
    localparam int FR_STL  [NFR] = '{0, 1, 0, 1, 0, 1};
    localparam int FR_OFF  [NFR] = '{0, 3, 240, 255, 16, 252};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic swap_en = 1'b0, host_wr_en = 1'b0, frame_inc = 1'b0, ctrl_reset = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic desc_we = 1'b0, desc_wready = 1'b0;
    logic [RAW-1:0] desc_widx = '0, desc_ridx = '0;
    logic [15:0] desc_wlen = '0, desc_wptr = '0;
    logic desc_rready, start = 1'b0, busy;
    logic [AW-1:0] wr_ptr;
    logic [7:0] queued;
    logic [RAW-1:0] ring_idx;
    logic out_valid, out_ready = 1'b1, out_last, irq_txend, irq_baddesc;
    logic [7:0] out_data;

    int checks = 0, fails = 0;
    int bytes_hs = 0;
    bit seen_txend = 0, seen_bad = 0;
    logic [7:0] model [BUFB];
    int wp = 0;
    int eidx = 0;

    always #2.5 clk = ~clk;

    tx_frame_fetcher #(.BUF_BYTES(BUFB), .RING_DEPTH(RING)) dut_i (
        .clk(clk), .rst(rst), .swap_en(swap_en), .host_wr_en(host_wr_en),
        .host_wr_data(host_wr_data), .frame_inc(frame_inc), .ctrl_reset(ctrl_reset),
        .desc_we(desc_we), .desc_widx(desc_widx), .desc_wready(desc_wready),
        .desc_wlen(desc_wlen), .desc_wptr(desc_wptr), .desc_ridx(desc_ridx),
        .desc_rready(desc_rready), .start(start), .busy(busy), .wr_ptr(wr_ptr),
        .queued(queued), .ring_idx(ring_idx), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .irq_txend(irq_txend), .irq_baddesc(irq_baddesc)
    );

    always @(posedge clk) begin
        if (out_valid && out_ready) bytes_hs <= bytes_hs + 1;
        if (irq_txend) seen_txend <= 1'b1;
        if (irq_baddesc) seen_bad <= 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] w, input bit sw);
        logic [31:0] st;
        @(negedge clk);
        swap_en = sw; host_wr_en = 1'b1; host_wr_data = w;
        st = sw ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        for (int k = 0; k < 4; k++) model[(wp + k) % BUFB] = st[8*k +: 8];
        wp = (wp + 4) % BUFB;
        @(negedge clk);
        host_wr_en = 1'b0; swap_en = 1'b0;
    endtask

    task automatic set_desc(input int idx, input bit rdy, input int len, input int ptr);
        @(negedge clk);
        desc_we = 1'b1; desc_widx = RAW'(idx); desc_wready = rdy;
        desc_wlen = 16'(len); desc_wptr = 16'(ptr);
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    task automatic bump;
        @(negedge clk); frame_inc = 1'b1;
        @(negedge clk); frame_inc = 1'b0;
    endtask

    task automatic kick;
        seen_txend = 0; seen_bad = 0; bytes_hs = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic collect(input int len, input int off, input bit stall, input string tag);
        int k = 0, cyc = 0, errs = 0, lerr = 0;
        while (k < len && cyc < 20000) begin
            if (cyc != 0) @(negedge clk);
            out_ready = (stall && (cyc % 3 == 1)) ? 1'b0 : 1'b1;
            if (out_valid && out_ready) begin
                if (out_data !== model[(off + k) % BUFB]) errs++;
                if (out_last !== (k == len - 1)) lerr++;
                k++;
            end
            cyc++;
        end
        @(negedge clk);
        out_ready = 1'b1;
        chk(errs == 0 && k == len, tag, errs, 0);
        chk(lerr == 0, "R11 last marker", lerr, 0);
    endtask

    task automatic wait_idle;
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(5ns * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(wr_ptr == 0, "R1 reset wr_ptr", int'(wr_ptr), 0);
        chk(queued == 0, "R3 reset count", int'(queued), 0);
        chk(ring_idx == 0 && !busy, "R8 reset ring", int'(ring_idx), 0);
        chk(!out_valid, "R11 reset valid", int'(out_valid), 0);

        // fill the whole buffer; R1 pointer wrap
        for (int i = 0; i < 64; i++) begin
            host_write({8'(4*i+3) ^ 8'h3C, 8'(4*i+2), 8'(4*i+1) ^ 8'hC3, 8'(4*i)}, 1'b0);
            if (i == 62) chk(wr_ptr == 8'd252, "R1 pointer step", int'(wr_ptr), 252);
        end
        chk(wr_ptr == 0, "R1 pointer wrap", int'(wr_ptr), 0);

        // table walk: R5 offsets, R6 buffer wrap, R8 ring wrap, R9 completion
        for (int f = 0; f < NFR; f++) begin
            set_desc(eidx, 1'b1, FR_LEN[f], FR_PTR[f]);
            bump;
            chk(queued == 1, "R3 count after increment", int'(queued), 1);
            kick;
            collect(FR_LEN[f], FR_OFF[f], FR_STL[f] == 1, "R5 R6 frame bytes");
            wait_idle;
            chk(seen_txend && !seen_bad, "R9 txend only", {seen_txend, seen_bad}, 2);
            desc_ridx = RAW'(eidx);
            #0.1;
            chk(!desc_rready, "R8 ready cleared", int'(desc_rready), 0);
            eidx = (eidx + 1) % RING;
            chk(ring_idx == RAW'(eidx) && queued == 0, "R8 index and count", int'(ring_idx), eidx);
        end

        // R2 byte swap
        @(negedge clk); ctrl_reset = 1'b1; @(negedge clk); ctrl_reset = 1'b0;
        wp = 0; eidx = 0;
        host_write(32'h11223344, 1'b1);
        host_write(32'hA1B2C3D4, 1'b0);
        chk(model[0] == 8'h11 && model[4] == 8'hD4, "R2 model order", int'(model[0]), 'h11);
        set_desc(0, 1'b1, 8, 32'h1000);
        bump; kick;
        collect(8, 0, 1'b0, "R2 swapped bytes");
        wait_idle;
        eidx = 1;

        // R4 start with empty queue
        kick; wait_idle;
        chk(bytes_hs == 0, "R4 empty queue sends nothing", bytes_hs, 0);
        chk(seen_bad && !seen_txend, "R9 empty queue irq", {seen_txend, seen_bad}, 1);

        // R4 early stop at a descriptor that is not ready
        set_desc(1, 1'b1, 5, 32'h1000);
        set_desc(2, 1'b0, 5, 32'h1000);
        bump; bump;
        kick;
        collect(5, 0, 1'b0, "R4 first frame");
        wait_idle;
        chk(seen_bad && seen_txend, "R9 partial walk irq", {seen_txend, seen_bad}, 3);
        chk(queued == 1 && ring_idx == 2, "R4 stop leaves count", int'(queued), 1);

        // R10 control reset
        host_write(32'h0, 1'b0);
        @(negedge clk); frame_inc = 1'b1; ctrl_reset = 1'b1;
        @(negedge clk); frame_inc = 1'b0; ctrl_reset = 1'b0;
        chk(wr_ptr == 0 && queued == 0 && ring_idx == 0, "R10 clear", int'(queued), 0);
        wp = 0;

        // R7 oversize descriptor is skipped but retired
        set_desc(0, 1'b1, 1515, 32'h1000);
        set_desc(1, 1'b1, 3, 32'h1004);
        bump; bump;
        kick;
        collect(3, 4, 1'b0, "R7 next frame after skip");
        wait_idle;
        chk(bytes_hs == 3, "R7 oversize sends nothing", bytes_hs, 3);
        desc_ridx = 0; #0.1;
        chk(!desc_rready, "R7 oversize retired", int'(desc_rready), 0);
        chk(seen_txend && !seen_bad && queued == 0, "R9 skip counts as handled",
            {seen_txend, seen_bad}, 2);

        // R7 zero length, then maximum length frame wrapping the buffer many times
        set_desc(2, 1'b1, 0, 32'h1000);
        set_desc(3, 1'b1, 1514, 32'h1080);
        bump; bump;
        kick;
        collect(1514, 128, 1'b0, "R6 max length frame");
        wait_idle;
        chk(bytes_hs == 1514, "R7 zero length sends nothing", bytes_hs, 1514);
        chk(ring_idx == 0 && queued == 0, "R8 ring wrap", int'(ring_idx), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule